// File: doc/BRIEF.md
# Timer-Paced Serial Converter Frame Master

This block is the master side of a synchronous serial link to a sampling converter. It uses a 3-wire link plus an active-low chip select. A programmable divider turns the system clock into a serial clock. A sample timer counts whole serial-clock periods and opens one 16-bit frame each time it expires. Inside a frame the block shifts a 16-bit control word out, most significant bit first. At the same time it captures the 16-bit conversion result from the converter. At the end of the frame it hands the captured word to the system with a one-cycle valid strobe.

Frame starts always coincide with a rising serial-clock edge, and the interval is an integer count of serial-clock periods. Consecutive samples are therefore exactly equidistant. The block cannot produce a half-period interval, and it cannot start a frame on a partial clock. A mode input selects a chip-select level held for the whole word or a one-period sync pulse. The board is expected to invert the serial clock on its way to the converter. Data launched on the master's rising edge is therefore taken by the converter on the master's falling edge.

Top module: `adc_frame_master`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `csN` is 1, `sclk` is 0, `sdo` is 0, `resultValid` is 0 and `resultData` is 0.
- R2: While `en` is high, `sclk` toggles every `divSet`+1 system clocks, so one period lasts 2*(`divSet`+1) clocks. `divSet`=3 gives 8 clocks and `divSet`=1 gives 4. One cycle after `en` is low, `sclk` is 0 and `csN` is 1.
- R3: After `en` rises (with `divSet`=3), `sclk` rises once, falls, and rises again. `csN` falls on that second rising edge, which is 3*(`divSet`+1) = 12 clocks after the first enabled edge.
- R4: `csN` falls only on the same clock edge on which `sclk` rises.
- R5: Frame starts are exactly N serial-clock periods apart. N comes from `intervalN`, sampled at each frame start, and sets the gap up to the following start. A change made during a frame therefore alters only the gap after the next start.
- R6: An `intervalN` below 17 (including 0) is treated as 17. This gives a gap of 17 periods.
- R7: `ctrlWord` is sent on `sdo`, MSB first. One bit is launched on each rising `sclk` edge, starting at the frame-start edge. A receiver that samples on falling edges sees the whole word. `sdo` returns to 0 after the frame.
- R8: `sdi` is sampled on the 16 falling `sclk` edges of a frame, MSB first. On the 16th falling edge `resultData` takes the word, and `resultValid` is 1 for exactly one clock.
- R9: With `pulseMode`=0, `csN` stays low for 16 serial-clock periods, and `resultValid` is raised while `csN` is low.
- R10: With `pulseMode`=1, `csN` is low for exactly one serial-clock period at each frame start. The word is still transferred and captured as in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low stops the serial clock and aborts any frame |
| divSet | input | 8 | Half-period of the serial clock minus one, in system clocks |
| intervalN | input | 16 | Sample interval in serial-clock periods (minimum 17) |
| ctrlWord | input | 16 | Control word sent in each frame |
| pulseMode | input | 1 | 1: one-period frame sync; 0: chip select held for the word |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock (idle low) |
| csN | output | 1 | Active-low chip select / frame sync |
| sdo | output | 1 | Serial data to the converter |
| resultValid | output | 1 | One-cycle strobe when a result is captured |
| resultData | output | 16 | Last captured conversion word |

## Verification
Several control/result pairs are applied: alternating bits, all-ones against all-zeros, all-zeros against all-ones, and words with only the end bits set. Together they separate a reversed bit order, an off-by-one capture edge and a stuck data line. Interval runs use 20, a mid-frame change to 24, and the out-of-range values 5 and 0. These distinguish a timer that latches N at the frame start from one that reads it live, and show whether small values are clamped. Running the same frame in level mode and in pulse mode shows that the sync width changes while the data path does not.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;
  // strobes from the frame controller to the shift datapath
  typedef struct packed {
    logic load;     // frame start: load control word
    logic shift;    // rising edge inside frame: launch next bit
    logic capture;  // falling edge inside frame: sample sdi
    logic finish;   // this capture is the last bit of the word
    logic clear;    // idle: drop any partial word
  } fmStrobe_t;
endpackage

// File: rtl/adc_fm_ctrl.sv
module adc_fm_ctrl
  import adc_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  divSet,
  input  logic [INTV_W-1:0] intervalN,
  input  logic              pulseMode,
  output logic              sclk,
  output logic              csN,
  output fmStrobe_t         stb
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [INTV_W-1:0] MIN_N = INTV_W'(DATA_W + 1);

  logic [DIV_W-1:0]  divCnt;
  logic [INTV_W-1:0] tmrCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic sclkQ, csQ, armed, inFrame;
  logic halfDone, riseTick, fallTick, startNow;
  logic [INTV_W-1:0] effN;

  assign halfDone = en && (divCnt >= divSet);
  assign riseTick = halfDone && !sclkQ;
  assign fallTick = halfDone && sclkQ;
  assign startNow = riseTick && armed && (tmrCnt == '0);
  assign effN     = (intervalN < MIN_N) ? MIN_N : intervalN;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      divCnt  <= '0;
      sclkQ   <= 1'b0;
      armed   <= 1'b0;
      tmrCnt  <= '0;
      inFrame <= 1'b0;
      bitCnt  <= '0;
      csQ     <= 1'b1;
    end else begin
      if (halfDone) begin
        divCnt <= '0;
        sclkQ  <= ~sclkQ;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (riseTick) begin
        // first rising edge only arms: a frame needs a full period first
        if (!armed) armed <= 1'b1;
        else if (startNow) tmrCnt <= effN - 1'b1;
        else tmrCnt <= tmrCnt - 1'b1;
        if (startNow) begin
          inFrame <= 1'b1;
          bitCnt  <= '0;
          csQ     <= 1'b0;
        end else if (inFrame) begin
          if (bitCnt == CNT_W'(DATA_W)) begin
            inFrame <= 1'b0;
            csQ     <= 1'b1;
          end else if (pulseMode) begin
            csQ <= 1'b1;
          end
        end
      end
      if (fallTick && inFrame && bitCnt < CNT_W'(DATA_W))
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.load    = startNow;
    stb.shift   = riseTick && inFrame && !startNow;
    stb.capture = fallTick && inFrame && (bitCnt < CNT_W'(DATA_W));
    stb.finish  = stb.capture && (bitCnt == CNT_W'(DATA_W - 1));
    stb.clear   = rst || !en;
  end

  assign sclk = sclkQ;
  assign csN  = csQ;
endmodule

// File: rtl/adc_fm_datapath.sv
module adc_fm_datapath
  import adc_fm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fmStrobe_t         stb,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic              sdi,
  output logic              sdo,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData
);
  logic [DATA_W-1:0] txReg, rxReg;

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      txReg <= '0;
      rxReg <= '0;
    end else begin
      if (stb.load) txReg <= ctrlWord;
      else if (stb.shift) txReg <= {txReg[DATA_W-2:0], 1'b0};
      if (stb.capture) rxReg <= {rxReg[DATA_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= stb.finish;
      if (stb.finish) resultData <= {rxReg[DATA_W-2:0], sdi};
    end
  end

  assign sdo = txReg[DATA_W-1];
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  divSet,
  input  logic [INTV_W-1:0] intervalN,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic              pulseMode,
  input  logic              sdi,
  output logic              sclk,
  output logic              csN,
  output logic              sdo,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData
);
  fmStrobe_t stb;

  adc_fm_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .INTV_W(INTV_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .divSet(divSet), .intervalN(intervalN),
    .pulseMode(pulseMode), .sclk(sclk), .csN(csN), .stb(stb)
  );

  adc_fm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .ctrlWord(ctrlWord), .sdi(sdi),
    .sdo(sdo), .resultValid(resultValid), .resultData(resultData)
  );
endmodule

// File: rtl/adc_fm_checker.sv
module adc_fm_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic pulseMode,
  input logic sclk,
  input logic csN,
  input logic sdo,
  input logic resultValid
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csN && !sclk && !sdo && !resultValid));

  p_off_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclk && csN));

  p_cs_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> $rose(sclk));

  p_sdo_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(sdo)) |-> $rose(sclk));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  p_valid_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    (resultValid && !pulseMode) |-> !csN);
endmodule

bind adc_frame_master adc_fm_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .pulseMode(pulseMode), .sclk(sclk),
  .csN(csN), .sdo(sdo), .resultValid(resultValid)
);

// File: tb/adc_frame_master_tb.sv
`timescale 1ns/1ps
module adc_frame_master_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, en, pulseMode, sdi;
  logic [7:0]  divSet;
  logic [15:0] intervalN, ctrlWord;
  logic        sclk, csN, sdo, resultValid;
  logic [15:0] resultData;

  int vecs = 0;
  int errs = 0;

  // converter model: data out on master rising, samples on master falling
  logic [15:0] adcWord = 16'h0;
  logic [15:0] rxCtrl  = 16'h0;
  logic [4:0]  fallCount = 5'd31;
  always @(negedge sclk or negedge csN)
    if (sclk) fallCount <= 5'd0;
    else if (fallCount != 5'd31) fallCount <= fallCount + 5'd1;
  always @(negedge sclk) rxCtrl <= {rxCtrl[14:0], sdo};
  assign sdi = (fallCount < 5'd16) ? adcWord[4'd15 - fallCount[3:0]] : 1'b0;

  adc_frame_master u_dut (
    .clk(clk), .rst(rst), .en(en), .divSet(divSet), .intervalN(intervalN),
    .ctrlWord(ctrlWord), .pulseMode(pulseMode), .sdi(sdi), .sclk(sclk),
    .csN(csN), .sdo(sdo), .resultValid(resultValid), .resultData(resultData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitCsFall(output int n, output bit onRise);
    bit pc, ps;
    n = 0;
    do begin pc = csN; ps = sclk; tick(); n++; end while (!(pc && !csN));
    onRise = !ps && sclk;
  endtask

  task automatic waitCsRise(output int n);
    bit pc;
    n = 0;
    do begin pc = csN; tick(); n++; end while (!(!pc && csN));
  endtask

  task automatic waitSclkRise(output int n);
    bit ps;
    n = 0;
    do begin ps = sclk; tick(); n++; end while (!(!ps && sclk));
  endtask

  task automatic waitValid(output int n);
    n = 0;
    do begin tick(); n++; end while (!resultValid);
  endtask

  task automatic restart();
    en = 1'b0; tick(); tick(); en = 1'b1;
  endtask

  task automatic testReset();
    rst = 1'b1; en = 1'b0; repeat (3) tick();
    rst = 1'b0; tick();
    chk(csN && !sclk && !sdo && !resultValid && resultData == 16'h0,
        "R1 reset state", {csN, sclk, sdo, resultValid}, 4'b1000);
  endtask

  task automatic testSclk();
    int n;
    divSet = 8'd3; restart();
    waitSclkRise(n); waitSclkRise(n);
    chk(n == 8, "R2 sclk period div=3", n, 8);
    divSet = 8'd1; restart();
    waitSclkRise(n); waitSclkRise(n);
    chk(n == 4, "R2 sclk period div=1", n, 4);
    en = 1'b0; tick(); tick();
    chk(!sclk && csN, "R2 idle when disabled", {sclk, csN}, 2'b01);
    divSet = 8'd3;
  endtask

  task automatic testFirstFrame();
    int n; bit r;
    intervalN = 16'd20; restart();
    waitCsFall(n, r);
    chk(n == 12, "R3 first frame delay", n, 12);
    chk(r, "R4 cs falls with sclk rise", r, 1);
  endtask

  task automatic runFrame(input logic [15:0] cw, input logic [15:0] aw);
    int n, m; bit r;
    en = 1'b0; pulseMode = 1'b0; ctrlWord = cw; adcWord = aw; tick();
    restart();
    waitCsFall(n, r);
    chk(r, "R4 cs falls with sclk rise", r, 1);
    waitValid(n);
    chk(resultData == aw, "R8 captured word", resultData, aw);
    chk(!csN, "R9 valid while cs low", csN, 0);
    chk(rxCtrl == cw, "R7 control word sent", rxCtrl, cw);
    tick();
    chk(!resultValid, "R8 valid one cycle", resultValid, 0);
    waitCsRise(m);
    chk(n + 1 + m == 128, "R9 cs low 16 periods", n + 1 + m, 128);
    chk(!sdo, "R7 sdo idle after frame", sdo, 0);
  endtask

  task automatic testInterval();
    int n; bit r;
    intervalN = 16'd20; restart();
    waitCsFall(n, r); waitCsFall(n, r);
    chk(n == 160, "R5 gap N=20", n, 160);
    repeat (10) tick();
    intervalN = 16'd24;
    waitCsFall(n, r);
    chk(n == 150, "R5 change waits for boundary", n + 10, 160);
    waitCsFall(n, r);
    chk(n == 192, "R5 new gap N=24", n, 192);
  endtask

  task automatic testClamp(input logic [15:0] nv);
    int n; bit r;
    intervalN = nv; restart();
    waitCsFall(n, r); waitCsFall(n, r);
    chk(n == 136, "R6 interval clamped to 17", n, 136);
  endtask

  task automatic testPulse();
    int n, m; bit r;
    en = 1'b0; pulseMode = 1'b1; intervalN = 16'd20;
    ctrlWord = 16'hC35A; adcWord = 16'h3C69; tick();
    restart();
    waitCsFall(n, r);
    waitCsRise(n);
    chk(n == 8, "R10 sync one period", n, 8);
    waitValid(m);
    chk(n + m == 124, "R10 capture timing", n + m, 124);
    chk(resultData == 16'h3C69, "R10 word in pulse mode", resultData, 16'h3C69);
    chk(rxCtrl == 16'hC35A, "R10 control word in pulse mode", rxCtrl, 16'hC35A);
    chk(csN, "R10 cs high after pulse", csN, 1);
    pulseMode = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; pulseMode = 1'b0; divSet = 8'd3;
    intervalN = 16'd20; ctrlWord = 16'h0;
    testReset();
    testSclk();
    testFirstFrame();
    runFrame(16'h5A3C, 16'hA5C3);
    runFrame(16'hFFFF, 16'h0000);
    runFrame(16'h0000, 16'hFFFF);
    runFrame(16'h8001, 16'h8001);
    testInterval();
    testClamp(16'd5);
    testClamp(16'd0);
    testClamp(16'd17);
    testPulse();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule